// File: doc/BRIEF.md
# I2C Client Address Recognizer

This block handles the address phase of an I2C client. After a Start strobe it takes the first byte from SDA, one bit on each rising edge of SCL, with the most significant bit first. Bits 7:1 of that byte form the address and bit 0 is the R/W bit. The byte is compared against a programmable own address and against the all-zero general call address. The general call address is honoured only when its enable is set. If either address matches, the block pulls SDA low for the acknowledge clock. It also updates its status flags, copies the byte into a receive register and can pulse an interrupt request. It then waits for the host to send data.

SCL and SDA arrive already synchronized to `clk`. Start and Stop come from an external bus-condition detector as one-cycle strobes. The own address is ten bits wide. In 7-bit mode the low seven bits are compared. In 10-bit mode the first byte must carry the `11110` prefix and the two top own-address bits. Matching the second address byte is out of scope, and so are clock stretching and any data byte after the address.

The FSM has these states: `AM_IDLE` (ignore the bus), `AM_SHIFT` (collect the address byte), `AM_ACK_SETUP` (wait for the eighth SCL fall), `AM_ACK_DRIVE` (hold SDA low) and `AM_DATA` (wait for data). Its transitions are:
- Any state goes to IDLE on a Stop strobe.
- Any state goes to SHIFT on a Start strobe, with Stop winning if both arrive together.
- SHIFT goes to ACK_SETUP on the eighth SCL rise when an address matches.
- SHIFT goes to IDLE on the eighth SCL rise when no address matches.
- ACK_SETUP goes to ACK_DRIVE on an SCL fall.
- ACK_DRIVE goes to DATA on an SCL fall.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, `sda_pull`, `rx_full`, `gc_stat`, `rw_stat`, `da_stat` and `irq` are 0 and `rx_data` is 0.
- R2: After a Start, the byte is assembled from `sda_i` sampled on 8 SCL rising edges, with the MSB first. On a match `rx_data` equals that byte.
- R3: Byte 0x00 is acknowledged when `gc_en`=1, whatever the value of `ten_bit_en`. With `gc_en`=0 it is not acknowledged. Byte 0x01 (zero address with a read) is never acknowledged.
- R4: With `ten_bit_en`=0, a byte whose bits 7:1 equal `own_addr[6:0]` is acknowledged, unless those bits are all zero.
- R5: With `ten_bit_en`=1, a byte whose bits 7:1 equal `11110` followed by `own_addr[9:8]` is acknowledged, and 7-bit own-address matching is off.
- R6: `sda_pull` is 1 from the first clock after the eighth SCL fall until the first clock after the ninth SCL fall, and 0 at all other times in the address phase.
- R7: A general call match sets `gc_stat` to 1. An own match clears it. On any match, `rw_stat` takes bit 0 of the byte and `da_stat` is cleared. A byte that does not match leaves these flags unchanged.
- R8: On a match, `rx_full` is set and `rx_data` loaded on the eighth SCL rise, while SCL is still high. A Start clears `rx_full`.
- R9: `irq` pulses for one cycle, the cycle after the ninth SCL fall of an acknowledged byte, only when `addr_ie` and `start_ie` are both 1.
- R10: After an acknowledge, the first SCL rise sets `da_stat` to 1, and no further SDA pull happens until the next Start.
- R11: After a byte that does not match, the block ignores SCL and SDA until the next Start: no pull, no flag change.
- R12: A Start in mid-byte restarts bit collection. A Stop in mid-byte aborts the phase so that nothing is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| start_det | input | 1 | One-cycle Start condition strobe |
| stop_det | input | 1 | One-cycle Stop condition strobe |
| own_addr | input | OWN_W | Own client address (10 bits) |
| gc_en | input | 1 | General call recognition enable |
| ten_bit_en | input | 1 | 10-bit addressing mode |
| addr_ie | input | 1 | Address-match interrupt enable |
| start_ie | input | 1 | Client-start interrupt enable |
| sda_pull | output | 1 | Pull SDA low (acknowledge) |
| rx_data | output | BYTE_W | Last matched address byte |
| rx_full | output | 1 | Receive register holds a new byte |
| gc_stat | output | 1 | Last match was the general call |
| rw_stat | output | 1 | R/W bit of the last matched byte |
| da_stat | output | 1 | 0 = last byte was an address, 1 = data phase entered |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The assertions assume the following about the inputs:
- The configuration inputs (`gc_en`, `ten_bit_en`, `own_addr`, the enables) stay steady during a transfer.
- SCL stays low for at least one clock after each falling edge.
- Start and Stop come only as single-cycle strobes.

The bench changes configuration only between transfers, and each transfer begins with a Start pulse and ends with a Stop pulse. It drives SCL with two-cycle high and low phases. It sweeps every first-byte value under each combination of general-call enable, addressing mode and two own addresses, and rotates the interrupt enables across the sweep.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

    typedef enum logic [2:0] {
        AM_IDLE,
        AM_SHIFT,
        AM_ACK_SETUP,
        AM_ACK_DRIVE,
        AM_DATA
    } am_state_t;

endpackage

// File: rtl/i2c_am_scl_edge.sv
module i2c_am_scl_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) scl_q <= 1'b1;
        else        scl_q <= scl_i;
    end

    assign scl_rise = scl_i & ~scl_q;
    assign scl_fall = ~scl_i & scl_q;
endmodule

// File: rtl/i2c_am_shifter.sv
module i2c_am_shifter #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              restart,
    input  logic              scl_rise,
    input  logic              sda_i,
    output logic [BYTE_W-1:0] byte_next,
    output logic              byte_done
);
    localparam int unsigned CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic [BYTE_W-2:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;

    assign byte_next = {shreg, sda_i};
    assign byte_done = active && !restart && scl_rise && (bit_cnt == LAST_BIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (restart || !active) begin
            bit_cnt <= '0;
        end else if (scl_rise) begin
            shreg   <= byte_next[BYTE_W-2:0];
            bit_cnt <= bit_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_am_compare.sv
module i2c_am_compare #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned OWN_W  = 10
) (
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [OWN_W-1:0]  own_addr,
    input  logic              gc_en,
    input  logic              ten_bit_en,
    output logic              gc_hit,
    output logic              own_hit
);
    localparam int unsigned A_W   = BYTE_W - 1;
    localparam int unsigned HI_W  = OWN_W - BYTE_W;
    localparam int unsigned PRE_W = A_W - HI_W;
    localparam logic [PRE_W-1:0] TEN_PREFIX = {{(PRE_W-1){1'b1}}, 1'b0};

    logic [A_W-1:0] addr_f;
    logic           rw_bit;
    logic           seven_hit;
    logic           ten_hit;
    logic           unused_mid;

    assign addr_f     = byte_i[BYTE_W-1:1];
    assign rw_bit     = byte_i[0];
    assign unused_mid = ^own_addr[OWN_W-HI_W-1:A_W];

    always_comb begin
        gc_hit    = gc_en && (addr_f == '0) && !rw_bit;
        seven_hit = (addr_f == own_addr[A_W-1:0]) && (addr_f != '0);
        ten_hit   = (addr_f == {TEN_PREFIX, own_addr[OWN_W-1:OWN_W-HI_W]});
        own_hit   = ten_bit_en ? ten_hit : seven_hit;
    end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_am_pkg::*;
#(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned OWN_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [OWN_W-1:0]  own_addr,
    input  logic              gc_en,
    input  logic              ten_bit_en,
    input  logic              addr_ie,
    input  logic              start_ie,
    output logic              sda_pull,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_full,
    output logic              gc_stat,
    output logic              rw_stat,
    output logic              da_stat,
    output logic              irq
);
    am_state_t         state, state_nxt;
    logic              scl_rise, scl_fall;
    logic [BYTE_W-1:0] byte_next;
    logic              byte_done;
    logic              gc_hit, own_hit, any_hit;
    logic              bus_evt;

    assign bus_evt = start_det | stop_det;
    assign any_hit = gc_hit | own_hit;

    i2c_am_scl_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    i2c_am_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (state == AM_SHIFT),
        .restart   (bus_evt),
        .scl_rise  (scl_rise),
        .sda_i     (sda_i),
        .byte_next (byte_next),
        .byte_done (byte_done)
    );

    i2c_am_compare #(.BYTE_W(BYTE_W), .OWN_W(OWN_W)) u_cmp (
        .byte_i     (byte_next),
        .own_addr   (own_addr),
        .gc_en      (gc_en),
        .ten_bit_en (ten_bit_en),
        .gc_hit     (gc_hit),
        .own_hit    (own_hit)
    );

    // next-state logic
    always_comb begin
        state_nxt = state;
        if (stop_det) begin
            state_nxt = AM_IDLE;
        end else if (start_det) begin
            state_nxt = AM_SHIFT;
        end else begin
            unique case (state)
                AM_IDLE:      state_nxt = AM_IDLE;
                AM_SHIFT:     if (byte_done) state_nxt = any_hit ? AM_ACK_SETUP : AM_IDLE;
                AM_ACK_SETUP: if (scl_fall)  state_nxt = AM_ACK_DRIVE;
                AM_ACK_DRIVE: if (scl_fall)  state_nxt = AM_DATA;
                AM_DATA:      state_nxt = AM_DATA;
                default:      state_nxt = AM_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= AM_IDLE;
        else        state <= state_nxt;
    end

    // outputs and status flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_pull <= 1'b0;
            rx_data  <= '0;
            rx_full  <= 1'b0;
            gc_stat  <= 1'b0;
            rw_stat  <= 1'b0;
            da_stat  <= 1'b0;
            irq      <= 1'b0;
        end else begin
            sda_pull <= (state_nxt == AM_ACK_DRIVE);
            irq      <= 1'b0;
            if (start_det) rx_full <= 1'b0;
            if (!bus_evt) begin
                unique case (state)
                    AM_SHIFT: begin
                        if (byte_done && any_hit) begin
                            rx_data <= byte_next;
                            rx_full <= 1'b1;
                            gc_stat <= gc_hit;
                            rw_stat <= byte_next[0];
                            da_stat <= 1'b0;
                        end
                    end
                    AM_ACK_DRIVE: begin
                        if (scl_fall) irq <= addr_ie & start_ie;
                    end
                    AM_DATA: begin
                        if (scl_rise) da_stat <= 1'b1;
                    end
                    AM_IDLE, AM_ACK_SETUP: ;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk #(
    parameter int unsigned BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              stop_det,
    input logic              gc_en,
    input logic              addr_ie,
    input logic              start_ie,
    input logic              sda_pull,
    input logic [BYTE_W-1:0] rx_data,
    input logic              rx_full,
    input logic              gc_stat,
    input logic              rw_stat,
    input logic              da_stat,
    input logic              irq
);
    assert_ack_after_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> ($past(!scl_i) && rx_full));

    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(sda_pull) && $past(addr_ie && start_ie)));

    assert_gc_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gc_stat) |-> $past(gc_en));

    assert_gc_is_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && gc_stat) |-> ((rx_data == '0) && !rw_stat));

    assert_stop_no_pull_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_det) |-> !sda_pull);

    assert_full_marks_address_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> !da_stat);
endmodule

bind i2c_addr_match i2c_addr_match_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .stop_det (stop_det),
    .gc_en    (gc_en),
    .addr_ie  (addr_ie),
    .start_ie (start_ie),
    .sda_pull (sda_pull),
    .rx_data  (rx_data),
    .rx_full  (rx_full),
    .gc_stat  (gc_stat),
    .rw_stat  (rw_stat),
    .da_stat  (da_stat),
    .irq      (irq)
);

// File: tb/i2c_addr_match_bench.sv
`timescale 1ns/1ps
module i2c_addr_match_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1, sda = 1'b1;
    logic       start_det = 1'b0, stop_det = 1'b0;
    logic [9:0] own = 10'h0B3;
    logic       gc_en = 1'b0, ten = 1'b0, aie = 1'b0, sie = 1'b0;
    logic       sda_pull, rx_full, gc_stat, rw_stat, da_stat, irq;
    logic [7:0] rx_data;

    int nchk = 0, nfail = 0;
    int pull_cnt = 0, irq_cnt = 0;
    logic [7:0] cur_b = '0;
    logic [7:0] exp_rx = '0;
    logic exp_full = 0, exp_gc = 0, exp_rw = 0, exp_da = 0;

    always #10 clk = ~clk;

    i2c_addr_match u_i2c_addr_match (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .start_det(start_det), .stop_det(stop_det), .own_addr(own),
        .gc_en(gc_en), .ten_bit_en(ten), .addr_ie(aie), .start_ie(sie),
        .sda_pull(sda_pull), .rx_data(rx_data), .rx_full(rx_full),
        .gc_stat(gc_stat), .rw_stat(rw_stat), .da_stat(da_stat), .irq(irq)
    );

    always @(negedge clk) begin
        if (sda_pull === 1'b1) pull_cnt++;
        if (irq === 1'b1) irq_cnt++;
    end

    task automatic chk(input string req, input int act, input int expv);
        nchk++;
        if (act !== expv) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d (byte %02h)", req, act, expv, cur_b);
        end
    endtask

    task automatic clk_bit(input logic v);
        @(negedge clk) sda = v;
        @(negedge clk) scl = 1'b1;
        @(negedge clk);
        @(negedge clk) scl = 1'b0;
    endtask

    task automatic run_txn(input logic [7:0] b);
        logic gh, oh, m;
        int   ib, pb;
        string rq;
        gh = gc_en && (b == 8'h00);
        oh = ten ? (b[7:1] == {5'b11110, own[9:8]})
                 : ((b[7:1] == own[6:0]) && (b[7:1] != 7'd0));
        m  = gh | oh;
        rq = gh ? "R3 ack" : (ten ? "R5 ack" : "R4 ack");
        cur_b = b;
        @(negedge clk) start_det = 1'b1;
        @(negedge clk) begin start_det = 1'b0; scl = 1'b0; end
        exp_full = 1'b0;
        if (m) begin
            exp_full = 1'b1; exp_rx = b; exp_gc = gh; exp_rw = b[0]; exp_da = 1'b0;
        end
        ib = irq_cnt;
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk) sda = b[i];
            @(negedge clk) scl = 1'b1;
            @(negedge clk);
            if (i == 0) begin
                chk("R8 rx_full", rx_full, exp_full);
                chk("R2 rx_data", rx_data, exp_rx);
                chk("R7 gc_stat", gc_stat, exp_gc);
                chk("R7 rw_stat", rw_stat, exp_rw);
                chk("R7 da_stat", da_stat, exp_da);
                chk("R6 no early pull", sda_pull, 0);
            end
            @(negedge clk) scl = 1'b0;
        end
        @(negedge clk) begin sda = 1'b1; chk(rq, sda_pull, m); end
        @(negedge clk) scl = 1'b1;
        @(negedge clk) chk("R6 hold", sda_pull, m);
        @(negedge clk) scl = 1'b0;
        @(negedge clk) chk("R6 release", sda_pull, 0);
        pb = pull_cnt;
        for (int k = 0; k < 3; k++) clk_bit(b[k]);
        @(negedge clk);
        if (m) exp_da = 1'b1;
        chk(m ? "R10 no data pull" : "R11 ignored pull", pull_cnt - pb, 0);
        chk(m ? "R10 da_stat" : "R11 da_stat", da_stat, exp_da);
        chk("R11 rx_full", rx_full, exp_full);
        chk("R9 irq", irq_cnt - ib, int'(m && aie && sie));
        @(negedge clk) scl = 1'b1;
        @(negedge clk) stop_det = 1'b1;
        @(negedge clk) stop_det = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int pb;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 sda_pull", sda_pull, 0);
        chk("R1 rx_full", rx_full, 0);
        chk("R1 gc_stat", gc_stat, 0);
        chk("R1 rw_stat", rw_stat, 0);
        chk("R1 da_stat", da_stat, 0);
        chk("R1 irq", irq, 0);
        chk("R1 rx_data", rx_data, 0);

        for (int cfg = 0; cfg < 4; cfg++) begin
            for (int oi = 0; oi < 2; oi++) begin
                @(negedge clk);
                gc_en = cfg[0];
                ten   = cfg[1];
                own   = (oi != 0) ? 10'h17F : 10'h0B3;
                for (int b = 0; b < 256; b++) begin
                    logic [1:0] ie;
                    ie  = 2'(b + cfg * 2 + oi);
                    aie = ie[1];
                    sie = ie[0];
                    run_txn(8'(b));
                end
            end
        end

        // R12 directed: restart and abort in mid-byte
        @(negedge clk);
        gc_en = 1'b1; ten = 1'b0; own = 10'h0B3; aie = 1'b1; sie = 1'b1;
        @(negedge clk) start_det = 1'b1;
        @(negedge clk) begin start_det = 1'b0; scl = 1'b0; end
        for (int k = 0; k < 4; k++) clk_bit(1'b1);
        @(negedge clk) scl = 1'b1;
        run_txn(8'h66);
        chk("R12 restart rx_data", rx_data, 8'h66);

        pb = pull_cnt;
        cur_b = 8'h66;
        @(negedge clk) start_det = 1'b1;
        @(negedge clk) begin start_det = 1'b0; scl = 1'b0; end
        clk_bit(1'b0); clk_bit(1'b1); clk_bit(1'b1); clk_bit(1'b0);
        @(negedge clk) stop_det = 1'b1;
        @(negedge clk) stop_det = 1'b0;
        clk_bit(1'b0); clk_bit(1'b1); clk_bit(1'b1); clk_bit(1'b0); clk_bit(1'b1);
        @(negedge clk);
        chk("R12 abort pull", pull_cnt - pb, 0);
        chk("R12 abort rx_full", rx_full, 0);
        chk("R12 abort gc_stat", gc_stat, exp_gc);
        @(negedge clk) scl = 1'b1;

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end
endmodule